// File: doc/BRIEF.md
# Idle-Mode Core Clock Gating Controller

This controller manages a processor's idle low-power state by stopping only the CPU core clock. The peripherals, the memory controller and the system-level units stay clocked the whole time. Software asks for idle by writing the idle code into a two-bit power-mode field. The controller then waits until the core reports that its pipeline is empty, and only then drops the core clock enable. A later wake event turns the clock back on. The core then resumes in the frequency mode picked by a turbo-select input, and the mode field returns to run. Each write of the idle code therefore causes at most one idle period.

Whether an interrupt can wake the core depends on a control bit. When the bit is clear, any source that is pending and enabled at the unit level wakes the core, and the mask is not looked at. When the bit is set, the source must also be unmasked. Two active-low supply-fault pins pass through a two-flop synchronizer before use. While the core is idle, a fault either raises a sleep request at once or acts as an ordinary wake interrupt, depending on a fault-abort enable bit. An asynchronous active-low reset, released synchronously inside the block, overrides everything and always brings the core back to run.

Top module: `idle_clk_ctrl`

## Requirements
- R1: After reset, core_clk_en=1, sys_clk_en=1, idle=0, sleep_req=0 and resume_turbo=0.
- R2: A write of mode code 2'b01 while running requests idle. core_clk_en stays 1 for as long as pipe_empty is 0. In the cycle after pipe_empty is sampled as 1, core_clk_en goes to 0.
- R3: The idle flag goes to 1 in exactly the cycle in which core_clk_en goes to 0, and it is never 1 while core_clk_en is 1.
- R4: A qualifying wake event sampled while waiting for the pipeline to drain cancels the idle entry. core_clk_en stays 1, and a later pipe_empty does not enter idle.
- R5: With use_mask=0, a source that is pending and enabled wakes the core whatever its mask bit. A source that is pending but not enabled does not wake it.
- R6: With use_mask=1, a source wakes the core only if it is pending, enabled and unmasked (irq_unmask bit = 1). A masked source leaves the core idle.
- R7: A qualifying wake event sampled while idle sets core_clk_en=1 and idle=0 at the next clock edge. At that edge resume_turbo takes the value of turbo_sel.
- R8: After a wake, the mode field reads as run. With pipe_empty held at 1, the core does not enter idle again without a new write.
- R9: While idle with fault_abort_en=0, a low level on either fault pin raises sleep_req three edges later (two synchronizer stages, then the state register). core_clk_en stays 0, and sleep_req holds until reset.
- R10: While idle with fault_abort_en=1, a low level on either fault pin wakes the core through the normal wake path three edges later, with sleep_req staying 0.
- R11: sys_clk_en stays 1 at all times outside reset, including while idle and during a sleep request.
- R12: Reset asserted while idle or during a sleep request returns every output to its R1 value.
- R13: A write of mode code 2'b00, 2'b10 or 2'b11 does not request idle, even with pipe_empty=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the power-mode field |
| mode_wdata | input | 2 | Power-mode code written (2'b01 = idle, 2'b00 = run) |
| pipe_empty | input | 1 | Core pipeline has no instructions in flight |
| irq_pend | input | NUM_SRC | Per-source interrupt pending |
| irq_en | input | NUM_SRC | Per-source unit-level enable |
| irq_unmask | input | NUM_SRC | Per-source mask register, 1 = unmasked |
| use_mask | input | 1 | 1 = the mask applies to wake-up while idle |
| fault_abort_en | input | 1 | 1 = a supply fault wakes the core, 0 = a supply fault requests sleep |
| batt_fault_n | input | 1 | Asynchronous active-low battery fault |
| vdd_fault_n | input | 1 | Asynchronous active-low core supply fault |
| turbo_sel | input | 1 | Frequency mode to resume in |
| core_clk_en | output | 1 | Enable for the CPU core clock gate |
| sys_clk_en | output | 1 | Enable for peripheral, memory and system clocks |
| idle | output | 1 | Core is in idle |
| resume_turbo | output | 1 | Frequency mode captured at the last wake |
| sleep_req | output | 1 | Request to the sleep sequencer |

## Verification
The assertions check on every cycle that the idle flag never coexists with a running core clock and rises exactly as the enable falls, that the clock keeps running while the pipeline is busy, that an unmasked enabled interrupt always ends idle, that the resume mode matches turbo_sel at each restart, and that a sleep request holds. The bench scenarios are needed for the rest. They walk interrupt patterns under both mask settings, including ones that must not wake. They show the abort of an idle entry during draining and the one-entry-per-write behaviour. They exercise the fault paths with their synchronizer latency, the ignored non-idle mode codes, and reset out of idle and out of sleep.

// File: rtl/idle_ctl_pkg.sv
package idle_ctl_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SLEEP = 2'd2
  } pm_state_e;

  localparam logic [1:0] PM_MODE_RUN  = 2'b00;
  localparam logic [1:0] PM_MODE_IDLE = 2'b01;
endpackage

// File: rtl/idle_rst_sync.sv
module idle_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/idle_fault_sync.sv
module idle_fault_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_n,
  output logic             fault_any
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = pin_n;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign fault_any = |(~stage_q[STAGES-1]);
endmodule

// File: rtl/idle_wake_qual.sv
module idle_wake_qual #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] irq_pend,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic [NUM_SRC-1:0] irq_unmask,
  input  logic               use_mask,
  output logic               irq_wake
);
  logic [NUM_SRC-1:0] hit;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign hit[i] = irq_pend[i] & irq_en[i] & (irq_unmask[i] | ~use_mask);
    end
  endgenerate

  assign irq_wake = |hit;
endmodule

// File: rtl/idle_fsm.sv
module idle_fsm
  import idle_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  input  logic       pipe_empty,
  input  logic       irq_wake,
  input  logic       fault_any,
  input  logic       fault_abort_en,
  input  logic       turbo_sel,
  output logic       core_clk_en,
  output logic       sys_clk_en,
  output logic       idle,
  output logic       sleep_req,
  output logic       resume_turbo
);
  pm_state_e  state_q, state_d;
  logic [1:0] mode_q, mode_d;
  logic       turbo_q, turbo_d;
  logic       sys_en_q;
  logic       wake_evt;
  logic       fault_sleep;

  assign wake_evt    = irq_wake | (fault_any & fault_abort_en);
  assign fault_sleep = fault_any & ~fault_abort_en;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    turbo_d = turbo_q;
    unique case (state_q)
      ST_RUN: begin
        if (mode_wr) begin
          mode_d = mode_wdata;
        end else if (mode_q == PM_MODE_IDLE) begin
          if (wake_evt) begin
            mode_d = PM_MODE_RUN;
          end else if (pipe_empty) begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_IDLE: begin
        if (fault_sleep) begin
          state_d = ST_SLEEP;
        end else if (wake_evt) begin
          state_d = ST_RUN;
          mode_d  = PM_MODE_RUN;
          turbo_d = turbo_sel;
        end
      end
      ST_SLEEP: begin
        state_d = ST_SLEEP;
      end
      default: begin
        state_d = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      mode_q   <= PM_MODE_RUN;
      turbo_q  <= 1'b0;
      sys_en_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      mode_q   <= mode_d;
      turbo_q  <= turbo_d;
      sys_en_q <= 1'b1;
    end
  end

  assign core_clk_en  = (state_q == ST_RUN);
  assign idle         = (state_q == ST_IDLE);
  assign sleep_req    = (state_q == ST_SLEEP);
  assign resume_turbo = turbo_q;
  assign sys_clk_en   = sys_en_q;
endmodule

// File: rtl/idle_clk_ctrl.sv
module idle_clk_ctrl #(
  parameter int NUM_SRC     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wr,
  input  logic [1:0]         mode_wdata,
  input  logic               pipe_empty,
  input  logic [NUM_SRC-1:0] irq_pend,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic [NUM_SRC-1:0] irq_unmask,
  input  logic               use_mask,
  input  logic               fault_abort_en,
  input  logic               batt_fault_n,
  input  logic               vdd_fault_n,
  input  logic               turbo_sel,
  output logic               core_clk_en,
  output logic               sys_clk_en,
  output logic               idle,
  output logic               resume_turbo,
  output logic               sleep_req
);
  localparam int FAULT_PINS = 2;

  logic rst_n_int;
  logic fault_any;
  logic irq_wake;

  idle_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  idle_fault_sync #(.WIDTH(FAULT_PINS), .STAGES(SYNC_STAGES)) u_fault_sync (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .pin_n     ({batt_fault_n, vdd_fault_n}),
    .fault_any (fault_any)
  );

  idle_wake_qual #(.NUM_SRC(NUM_SRC)) u_wake_qual (
    .irq_pend   (irq_pend),
    .irq_en     (irq_en),
    .irq_unmask (irq_unmask),
    .use_mask   (use_mask),
    .irq_wake   (irq_wake)
  );

  idle_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .mode_wr        (mode_wr),
    .mode_wdata     (mode_wdata),
    .pipe_empty     (pipe_empty),
    .irq_wake       (irq_wake),
    .fault_any      (fault_any),
    .fault_abort_en (fault_abort_en),
    .turbo_sel      (turbo_sel),
    .core_clk_en    (core_clk_en),
    .sys_clk_en     (sys_clk_en),
    .idle           (idle),
    .sleep_req      (sleep_req),
    .resume_turbo   (resume_turbo)
  );
endmodule

// File: rtl/idle_clk_ctrl_chk.sv
module idle_clk_ctrl_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pipe_empty,
  input logic [NUM_SRC-1:0] irq_pend,
  input logic [NUM_SRC-1:0] irq_en,
  input logic [NUM_SRC-1:0] irq_unmask,
  input logic               fault_abort_en,
  input logic               turbo_sel,
  input logic               core_clk_en,
  input logic               sys_clk_en,
  input logic               idle,
  input logic               resume_turbo,
  input logic               sleep_req
);
  p_idle_no_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !core_clk_en);

  p_idle_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> $fell(core_clk_en));

  p_busy_pipe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && !pipe_empty) |=> core_clk_en);

  p_unmasked_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && fault_abort_en && |(irq_pend & irq_en & irq_unmask)) |=> (core_clk_en && !idle));

  p_resume_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> (resume_turbo == $past(turbo_sel)));

  p_sleep_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> (sleep_req && !core_clk_en));

  p_sys_clk_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sys_clk_en);
endmodule

bind idle_clk_ctrl idle_clk_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n_int),
  .pipe_empty     (pipe_empty),
  .irq_pend       (irq_pend),
  .irq_en         (irq_en),
  .irq_unmask     (irq_unmask),
  .fault_abort_en (fault_abort_en),
  .turbo_sel      (turbo_sel),
  .core_clk_en    (core_clk_en),
  .sys_clk_en     (sys_clk_en),
  .idle           (idle),
  .resume_turbo   (resume_turbo),
  .sleep_req      (sleep_req)
);

// File: tb/idle_clk_ctrl_tb.sv
module idle_clk_ctrl_tb;
  localparam int N = 8;
  localparam int NV = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         mode_wr;
  logic [1:0]   mode_wdata;
  logic         pipe_empty;
  logic [N-1:0] irq_pend, irq_en, irq_unmask;
  logic         use_mask, fault_abort_en, batt_fault_n, vdd_fault_n, turbo_sel;
  logic         core_clk_en, sys_clk_en, idle, resume_turbo, sleep_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // vector: {use_mask, pend, en, unmask, expect_wake}
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 8'h01, 8'h01, 8'h00, 1'b1},
    {1'b1, 8'h01, 8'h01, 8'h00, 1'b0},
    {1'b1, 8'h01, 8'h01, 8'h01, 1'b1},
    {1'b0, 8'h01, 8'h00, 8'hFF, 1'b0},
    {1'b0, 8'h00, 8'hFF, 8'hFF, 1'b0},
    {1'b1, 8'h80, 8'h80, 8'h80, 1'b1},
    {1'b1, 8'hF0, 8'h0F, 8'hFF, 1'b0},
    {1'b1, 8'h3C, 8'h24, 8'h04, 1'b1}
  };

  idle_clk_ctrl #(.NUM_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .pipe_empty(pipe_empty), .irq_pend(irq_pend), .irq_en(irq_en),
    .irq_unmask(irq_unmask), .use_mask(use_mask), .fault_abort_en(fault_abort_en),
    .batt_fault_n(batt_fault_n), .vdd_fault_n(vdd_fault_n), .turbo_sel(turbo_sel),
    .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en), .idle(idle),
    .resume_turbo(resume_turbo), .sleep_req(sleep_req)
  );

  always #2 clk = ~clk;

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clear_irq();
    irq_pend = '0; irq_en = '0; irq_unmask = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(3);
  endtask

  task automatic enter_idle();
    clear_irq();
    pipe_empty = 1'b1;
    mode_wr = 1'b1; mode_wdata = 2'b01;
    tick();
    mode_wr = 1'b0;
    tick();
  endtask

  initial begin
    rst_n = 1'b0; mode_wr = 1'b0; mode_wdata = 2'b00; pipe_empty = 1'b0;
    clear_irq(); use_mask = 1'b0; fault_abort_en = 1'b1;
    batt_fault_n = 1'b1; vdd_fault_n = 1'b1; turbo_sel = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(3);

    // R1 reset state
    chk("R1 core_clk_en", core_clk_en, 1'b1);
    chk("R1 sys_clk_en", sys_clk_en, 1'b1);
    chk("R1 idle", idle, 1'b0);
    chk("R1 sleep_req", sleep_req, 1'b0);
    chk("R1 resume_turbo", resume_turbo, 1'b0);

    // R5 R6 R7: wake qualification table
    for (int v = 0; v < NV; v++) begin
      enter_idle();
      chk("R2 idle entered", idle, 1'b1);
      use_mask   = VEC[v][25];
      irq_pend   = VEC[v][24:17];
      irq_en     = VEC[v][16:9];
      irq_unmask = VEC[v][8:1];
      turbo_sel  = v[0];
      tick();
      chk(use_mask ? "R6 wake by pattern" : "R5 wake by pattern", core_clk_en, VEC[v][0]);
      if (VEC[v][0]) begin
        chk("R7 resume_turbo", resume_turbo, v[0]);
      end else begin
        chk("R3 still idle", idle, 1'b1);
        use_mask = 1'b0; irq_pend = 8'h01; irq_en = 8'h01;
        tick();
        chk("R7 wake after release", core_clk_en, 1'b1);
      end
      clear_irq();
      tick();
    end

    // R2 busy pipeline holds the clock
    use_mask = 1'b0;
    pipe_empty = 1'b0;
    mode_wr = 1'b1; mode_wdata = 2'b01;
    tick();
    mode_wr = 1'b0;
    tick(5);
    chk("R2 clock held while busy", core_clk_en, 1'b1);
    chk("R3 no idle while busy", idle, 1'b0);
    pipe_empty = 1'b1;
    tick();
    chk("R2 clock stops after drain", core_clk_en, 1'b0);
    chk("R3 idle with clock stop", idle, 1'b1);
    irq_pend = 8'h02; irq_en = 8'h02;
    tick();
    clear_irq();
    // R8 no re-entry without a new write
    tick(4);
    chk("R8 no second idle entry", core_clk_en, 1'b1);

    // R4 abort during drain
    pipe_empty = 1'b0;
    mode_wr = 1'b1; mode_wdata = 2'b01;
    tick();
    mode_wr = 1'b0;
    irq_pend = 8'h10; irq_en = 8'h10;
    tick();
    clear_irq();
    pipe_empty = 1'b1;
    tick(4);
    chk("R4 aborted entry clock on", core_clk_en, 1'b1);
    chk("R4 aborted entry not idle", idle, 1'b0);

    // R13 non-idle codes
    for (int c = 0; c < 4; c++) begin
      if (c != 1) begin
        mode_wr = 1'b1; mode_wdata = c[1:0];
        tick();
        mode_wr = 1'b0;
        tick(3);
        chk("R13 non-idle code ignored", core_clk_en, 1'b1);
      end
    end

    // R10 fault with abort enable wakes
    fault_abort_en = 1'b1;
    enter_idle();
    vdd_fault_n = 1'b0;
    tick(2);
    chk("R10 still idle during sync", idle, 1'b1);
    tick();
    chk("R10 fault wakes", core_clk_en, 1'b1);
    chk("R10 no sleep", sleep_req, 1'b0);
    vdd_fault_n = 1'b1;
    tick(4);

    // R9 fault without abort enable requests sleep
    fault_abort_en = 1'b0;
    enter_idle();
    batt_fault_n = 1'b0;
    tick(2);
    chk("R9 no sleep before sync", sleep_req, 1'b0);
    tick();
    chk("R9 sleep_req raised", sleep_req, 1'b1);
    chk("R9 clock stays off", core_clk_en, 1'b0);
    batt_fault_n = 1'b1;
    irq_pend = 8'h01; irq_en = 8'h01;
    tick(4);
    chk("R9 sleep held", sleep_req, 1'b1);
    chk("R11 sys clock during sleep", sys_clk_en, 1'b1);
    clear_irq();

    // R12 reset out of sleep
    do_reset();
    chk("R12 clock after reset from sleep", core_clk_en, 1'b1);
    chk("R12 sleep cleared", sleep_req, 1'b0);

    // R12 reset out of idle
    enter_idle();
    chk("R11 sys clock during idle", sys_clk_en, 1'b1);
    do_reset();
    chk("R12 clock after reset from idle", core_clk_en, 1'b1);
    chk("R12 idle cleared", idle, 1'b0);
    chk("R12 turbo cleared", resume_turbo, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule